// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Latch Readback

This block is one 8-bit general-purpose port of a small controller. It has no direction register. Each bit has an output latch. A latch bit at zero pulls its pin low. A latch bit at one releases the pin, so the pin acts as an input that sits high unless something outside pulls it down. The pad is not part of the block. The block drives it through four digital enables per bit:

- a strong pull-down;
- a short strong pull-up burst that speeds up a rising edge;
- a keeper pull-up that follows the sensed pin level;
- a very weak pull-up that follows the latch.

The CPU can write the latch as a whole byte or one bit at a time. The CPU reads the port through one data output. A read-modify-write flag selects the source of that data. With the flag set, the data comes from the latch. With the flag clear, the data comes from the synchronized pins. This keeps a bit that is loaded by an external transistor, and so sits below the logic-high threshold, from being read back as zero and then written back as zero. A single-bit write is itself a read-modify-write: the seven other bits come from the latch.

The latch changes on the clock edge that takes the write. All pin-facing enables come from a registered copy of the latch, so they change one cycle later.

Top module: `qbd_port`

## Requirements
- R1: After reset, the latch reads 0xFF, `pd_en` is 0x00, `spu_en` is 0x00 and `wpu_en` is 0xFF.
- R2: Writing 1 to a bit whose latch is 0 returns that bit to input behaviour: its `pd_en` bit deasserts and the pin is released.
- R3: When the driven copy of a latch bit goes from 0 to 1, that bit of `spu_en` is high for exactly 2 clock cycles, starting in the cycle in which the driven copy rises.
- R4: A bit of `pd_en` is high exactly when the driven copy of its latch bit is 0.
- R5: A bit of `wpu_en` is high exactly when the driven copy of its latch bit is 1.
- R6: `keep_en` equals the pin levels after a two-flop synchronizer, i.e. it reflects `pin_in` two clock edges later.
- R7: With `rd_rmw` = 1, `rd_data` returns the latch. With `rd_rmw` = 0, it returns the synchronized pins, which lag `pin_in` by two edges.
- R8: A bit write (`wr_bit_en` = 1, 3-bit address `wr_bit_addr`, where bit n is value 2^n) loads `wr_bit_val` into the addressed bit and keeps the other seven latch bits.
- R9: When `wr_byte_en` and `wr_bit_en` are both high in the same cycle, the byte write wins and the bit write is dropped.
- R10: The latch takes a write on the edge that samples it. The pin-facing enables (`pd_en`, `spu_en`, `wpu_en`) reflect that write one cycle later.
- R11: A 1-to-0 change of the driven copy during a strong pull-up burst ends the burst in that same cycle. `spu_en` and `pd_en` are never both high for a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_byte_en | input | 1 | Load the whole latch from `wr_byte_data` |
| wr_byte_data | input | 8 | Byte write data |
| wr_bit_en | input | 1 | Load one latch bit |
| wr_bit_addr | input | 3 | Bit index for a bit write |
| wr_bit_val | input | 1 | Value for the addressed bit |
| rd_rmw | input | 1 | 1 = the read comes from the latch (read-modify-write), 0 = the read comes from the pins |
| pin_in | input | 8 | Sensed pad levels |
| rd_data | output | 8 | Read data |
| pd_en | output | 8 | Strong pull-down enable per bit |
| spu_en | output | 8 | Momentary strong pull-up enable per bit |
| keep_en | output | 8 | Keeper pull-up enable per bit |
| wpu_en | output | 8 | Very weak pull-up enable per bit |

## Verification
The assertions assume the CPU issues at most one write per cycle. A byte write and a bit write may arrive together, and the assertions assume the byte write then prevails. They also assume that `pin_in` may change at any time, since it only feeds the synchronizer.

The stimulus spaces most writes at least six cycles apart, so that each burst and each enable lag settles before the next write. The one exception is the cancellation case, which deliberately writes 1 and then 0 on back-to-back cycles.

The pad is modelled as a resolved wire. A pin is low when `pd_en` or an external pull-down is active, and high otherwise. This keeps the pin levels consistent with the enables the block drives.

// File: rtl/qbd_pkg.sv
`timescale 1ns/1ps
package qbd_pkg;
  // source selection for the CPU-side read path
  typedef enum logic {
    RD_PIN   = 1'b0,
    RD_LATCH = 1'b1
  } rd_src_e;

  parameter int unsigned QBD_WIDTH_DEFAULT = 8;
  parameter int unsigned QBD_PULSE_DEFAULT = 2;
  parameter int unsigned QBD_SYNC_DEFAULT  = 2;
endpackage

// File: rtl/qbd_rst_sync.sv
`timescale 1ns/1ps
module qbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] rst_ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end

  assign rst_n_s = rst_ff[1];
endmodule

// File: rtl/qbd_sync.sv
`timescale 1ns/1ps
module qbd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  // first stage samples the asynchronous pads; reset value is "pulled high"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qbd_latch.sv
`timescale 1ns/1ps
module qbd_latch #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [WIDTH-1:0] byte_data,
  input  logic             bit_en,
  input  logic [AW-1:0]    bit_addr,
  input  logic             bit_val,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] latch_d;
  logic             ld_en;

  // next-state: byte write first, otherwise merge one bit into the held byte
  always_comb begin
    latch_d = latch_q;
    if (byte_en) begin
      latch_d = byte_data;
    end else if (bit_en) begin
      latch_d[bit_addr] = bit_val;
    end
  end

  assign ld_en = byte_en | bit_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= '1;
    else if (ld_en) latch_q <= latch_d;
  end

  // R9: byte write wins over a coincident bit write
  p_byte_prio_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    byte_en |=> (latch_q == $past(byte_data)));

  // R8: a lone bit write leaves every other bit untouched
  p_bit_isolated_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_en && bit_en) |=>
      (((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(bit_addr))) == '0));

  // R8: addressed bit carries the written value
  p_bit_value_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_en && bit_en) |=> (latch_q[$past(bit_addr)] == $past(bit_val)));
endmodule

// File: rtl/qbd_pin_drive.sv
`timescale 1ns/1ps
module qbd_pin_drive #(
  parameter int unsigned PULSE_CYCLES = 2,
  localparam int unsigned CW          = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_bit,
  input  logic pin_sync,
  output logic pd_en,
  output logic spu_en,
  output logic keep_en,
  output logic wpu_en
);
  logic          drive_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state of the strong pull-up burst counter
  always_comb begin
    if (!latch_bit)                  cnt_d = '0;                // cancel on a falling latch
    else if (!drive_q)               cnt_d = CW'(PULSE_CYCLES); // 0 -> 1 transition
    else if (cnt_q != '0)            cnt_d = cnt_q - CW'(1);
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      drive_q <= latch_bit;
      cnt_q   <= cnt_d;
    end
  end

  assign pd_en   = ~drive_q;
  assign wpu_en  = drive_q;
  assign spu_en  = (cnt_q != '0);
  assign keep_en = pin_sync;

  // R3: burst starts in the cycle the driven copy rises
  p_burst_start_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> spu_en);

  // R3: burst lasts past its first cycle when the latch stays high
  if (PULSE_CYCLES >= 2) begin : g_len
    p_burst_second_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(drive_q) && latch_bit) |=> spu_en);
  end

  // R3: no burst without a preceding rise
  p_burst_cause_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> $rose(drive_q));

  // R11: a fall during the burst ends it immediately, no overlap with pull-down
  p_cancel_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && !latch_bit) |=> (!spu_en && pd_en));

  p_no_fight_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    !(spu_en && pd_en));
endmodule

// File: rtl/qbd_port.sv
`timescale 1ns/1ps
module qbd_port
  import qbd_pkg::*;
#(
  parameter int unsigned WIDTH        = QBD_WIDTH_DEFAULT,
  parameter int unsigned PULSE_CYCLES = QBD_PULSE_DEFAULT,
  parameter int unsigned SYNC_STAGES  = QBD_SYNC_DEFAULT,
  localparam int unsigned AW          = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte_en,
  input  logic [WIDTH-1:0] wr_byte_data,
  input  logic             wr_bit_en,
  input  logic [AW-1:0]    wr_bit_addr,
  input  logic             wr_bit_val,
  input  logic             rd_rmw,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] spu_en,
  output logic [WIDTH-1:0] keep_en,
  output logic [WIDTH-1:0] wpu_en
);
  logic             rst_n_s;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_s;
  rd_src_e          rd_src;

  qbd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  qbd_latch #(.WIDTH(WIDTH)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .byte_en   (wr_byte_en),
    .byte_data (wr_byte_data),
    .bit_en    (wr_bit_en),
    .bit_addr  (wr_bit_addr),
    .bit_val   (wr_bit_val),
    .latch_q   (latch_q)
  );

  qbd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (pin_in),
    .q     (pin_s)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    qbd_pin_drive #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .latch_bit (latch_q[i]),
      .pin_sync  (pin_s[i]),
      .pd_en     (pd_en[i]),
      .spu_en    (spu_en[i]),
      .keep_en   (keep_en[i]),
      .wpu_en    (wpu_en[i])
    );
  end

  // read path: latch for read-modify-write, synchronized pins otherwise
  assign rd_src = rd_src_e'(rd_rmw);

  always_comb begin
    if (rd_src == RD_LATCH) rd_data = latch_q;
    else                    rd_data = pin_s;
  end

  // R10 / R4: pull-down reflects the latch one cycle late
  p_pd_lag_r10 : assert property (@(posedge clk) disable iff (!rst_n_s)
    pd_en == ~$past(latch_q));

  // R5: very weak pull-up reflects the latch one cycle late
  p_wpu_lag_r5 : assert property (@(posedge clk) disable iff (!rst_n_s)
    wpu_en == $past(latch_q));

  // R1: first cycle out of reset shows a released, high port
  p_reset_state_r1 : assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (latch_q == '1 && spu_en == '0));
endmodule

// File: tb/qbd_port_bench.sv
`timescale 1ns/1ps
module qbd_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_byte_en, wr_bit_en, wr_bit_val, rd_rmw;
  logic [7:0] wr_byte_data;
  logic [2:0] wr_bit_addr;
  logic [7:0] ext_low;
  wire  [7:0] pin_in;
  logic [7:0] rd_data, pd_en, spu_en, keep_en, wpu_en;

  always #2.5 clk = ~clk;

  // resolved pad: low if the block or the outside pulls it down
  assign pin_in = ~(pd_en | ext_low);

  qbd_port u_qbd_port (
    .clk(clk), .rst_n(rst_n),
    .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_addr(wr_bit_addr), .wr_bit_val(wr_bit_val),
    .rd_rmw(rd_rmw), .pin_in(pin_in),
    .rd_data(rd_data), .pd_en(pd_en), .spu_en(spu_en),
    .keep_en(keep_en), .wpu_en(wpu_en)
  );

  typedef enum {S_RD, S_PD, S_SPU, S_KEEP, S_WPU} sel_e;
  typedef struct {
    int         due;
    sel_e       sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  logic [7:0] m_latch = 8'hFF;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pick(sel_e s);
    case (s)
      S_RD:    return rd_data;
      S_PD:    return pd_en;
      S_SPU:   return spu_en;
      S_KEEP:  return keep_en;
      default: return wpu_en;
    endcase
  endfunction

  // scoreboard insert, kept ordered by due cycle
  task automatic expect_at(int due, sel_e s, logic [7:0] v, string r);
    item_t it;
    int    pos;
    it.due = due; it.sel = s; it.exp = v; it.req = r;
    pos = q.size();
    for (int k = 0; k < q.size(); k++) begin
      if (q[k].due > due) begin pos = k; break; end
    end
    q.insert(pos, it);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = pick(it.sel);
      n_chk++;
      if (it.due != cyc || act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %s at cycle %0d actual %02h expected %02h",
                 it.req, it.sel.name(), cyc, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  // one write, expectations derived from the requirements
  task automatic apply(logic be, logic [7:0] bd, logic bte, logic [2:0] ba,
                       logic bv, string rd_req);
    logic [7:0] old, nxt, rise;
    int c;
    c   = cyc;
    old = m_latch;
    nxt = old;
    if (be)       nxt = bd;
    else if (bte) nxt[ba] = bv;
    rise    = nxt & ~old;
    m_latch = nxt;
    expect_at(c + 1, S_RD,  nxt,  rd_req);
    expect_at(c + 1, S_PD,  ~old, "R10 enables lag latch");
    expect_at(c + 2, S_PD,  ~nxt, "R4 pull-down from latch zero");
    expect_at(c + 2, S_WPU, nxt,  "R5 weak pull-up from latch one");
    expect_at(c + 2, S_SPU, rise, "R3 burst cycle 1");
    expect_at(c + 3, S_SPU, rise, "R3 burst cycle 2");
    expect_at(c + 4, S_SPU, 8'h00, "R3 burst end");
    wr_byte_en = be; wr_byte_data = bd;
    wr_bit_en = bte; wr_bit_addr = ba; wr_bit_val = bv;
    step(1);
    wr_byte_en = 1'b0; wr_bit_en = 1'b0;
    step(6);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0;
    wr_byte_en = 1'b0; wr_byte_data = 8'h00;
    wr_bit_en = 1'b0; wr_bit_addr = 3'd0; wr_bit_val = 1'b0;
    rd_rmw = 1'b1; ext_low = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    c = cyc;
    expect_at(c + 1, S_RD,   8'hFF, "R1 latch after reset");
    expect_at(c + 1, S_PD,   8'h00, "R1 pull-down after reset");
    expect_at(c + 1, S_SPU,  8'h00, "R1 burst after reset");
    expect_at(c + 1, S_WPU,  8'hFF, "R1 weak pull-up after reset");
    expect_at(c + 1, S_KEEP, 8'hFF, "R6 keeper with high pins");
    step(2);

    // byte patterns
    apply(1'b1, 8'h5A, 1'b0, 3'd0, 1'b0, "R7 latch read of byte");
    expect_at(cyc + 1, S_KEEP, 8'h5A, "R6 keeper follows low pins");
    step(2);
    apply(1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, "R2 ones return to input");
    expect_at(cyc + 1, S_PD, 8'h00, "R2 pull-down released");
    expect_at(cyc + 1, S_KEEP, 8'hFF, "R6 keeper after release");
    step(2);
    apply(1'b1, 8'h00, 1'b0, 3'd0, 1'b0, "R7 latch read all zero");
    apply(1'b1, 8'hA5, 1'b0, 3'd0, 1'b0, "R7 latch read A5");

    // bit writes on a mixed pattern
    apply(1'b0, 8'h00, 1'b1, 3'd0, 1'b1, "R8 bit 0 set keeps others");
    apply(1'b0, 8'h00, 1'b1, 3'd7, 1'b0, "R8 bit 7 clear keeps others");
    apply(1'b0, 8'h00, 1'b1, 3'd3, 1'b1, "R8 bit 3 set keeps others");

    // R9 priority
    apply(1'b1, 8'h0F, 1'b1, 3'd7, 1'b1, "R9 byte beats bit");
    apply(1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, "R2 all released");

    // R11 cancel during burst
    apply(1'b0, 8'h00, 1'b1, 3'd5, 1'b0, "R8 bit 5 clear");
    c = cyc;
    expect_at(c + 1, S_RD,  8'hFF, "R10 latch takes 1 at once");
    expect_at(c + 2, S_RD,  8'hDF, "R10 latch takes 0 at once");
    expect_at(c + 2, S_SPU, 8'h20, "R3 burst begins");
    expect_at(c + 2, S_PD,  8'h00, "R11 no pull-down in burst");
    expect_at(c + 3, S_SPU, 8'h00, "R11 burst cancelled");
    expect_at(c + 3, S_PD,  8'h20, "R11 pull-down after cancel");
    wr_bit_en = 1'b1; wr_bit_addr = 3'd5; wr_bit_val = 1'b1;
    step(1);
    wr_bit_val = 1'b0;
    step(1);
    wr_bit_en = 1'b0;
    m_latch = 8'hDF;
    step(6);
    apply(1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, "R2 released again");

    // R7 pin read vs latch read under an external pull-down
    c = cyc;
    rd_rmw = 1'b0;
    ext_low = 8'h01;
    expect_at(c + 1, S_RD,   8'hFF, "R7 pin read before sync");
    expect_at(c + 2, S_RD,   8'hFE, "R7 pin read after 2 edges");
    expect_at(c + 2, S_KEEP, 8'hFE, "R6 keeper drops with pin");
    step(2);
    rd_rmw = 1'b1;
    expect_at(cyc + 1, S_RD, 8'hFF, "R7 latch read ignores low pin");
    step(2);
    apply(1'b0, 8'h00, 1'b1, 3'd1, 1'b0, "R8 rmw keeps latched one on low pin");
    expect_at(cyc + 1, S_KEEP, 8'hFC, "R6 keeper with two low pins");
    step(2);
    ext_low = 8'h00;
    apply(1'b0, 8'h00, 1'b1, 3'd1, 1'b1, "R8 bit 1 restored");

    step(4);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule